// File: doc/BRIEF.md
# Command-Word Serial Register Bridge

This block gives a host a way into the byte-wide registers of a device that sits behind a two-wire serial bus. The host writes a single 32-bit command word. That word carries a register index, a direction flag and, for writes, a data byte. The bridge then runs the whole indexed transaction on the bus without further help from the host.

A write goes out as start, device address with the write bit, index, data, stop. A read goes out as start, device address with the write bit, index, repeated start, device address with the read bit, one received byte, a not-acknowledge from the master, and stop.

The host learns how the transaction went from three places:
- a busy bit in the command register, which clears by itself when the transfer ends;
- a status register holding the last byte read;
- two sticky flags in the same status register, one for a missing acknowledge and one for a command that was refused because the bridge was busy. The host clears each flag by writing a one to its bit.

A timing register sets the lengths of the high and low clock phases.

The clock line is driven push-pull. The data line is open-drain: an output enable pulls it low, and an external pull-up brings it high.

Top module: `rbi_bridge_top`

## Requirements
- R1: After reset the bridge is idle:
  - the command readback and status read 0;
  - the timing register (select 2) reads 0x01010101;
  - SCL is high and the data line is released.
- R2: Command layout at select 0:
  - bits 24:17 hold the register index;
  - bit 8 selects write (1) or read (0);
  - bits 7:0 hold the write data.
  
  An accepted command shows the busy bit (bit 16 of the command readback) in the next cycle. The busy bit clears by itself when the transfer ends, and the bus is released at that point.
- R3: A write command sends start, {address,0}, index, data, stop. The addressed slave register then holds the data byte.
- R4: A read command sends start, {address,0}, index, repeated start, {address,1}, then receives one byte, sends a NACK and sends stop. The received byte appears in status bits 31:24 once busy has cleared.
- R5: A missing acknowledge in any address, index or data slot does three things: it sets the sticky abort flag (status bit 0), it ends the transfer with stop, and it clears busy. Writing 1 to status bit 0 clears the flag, and writing 0 leaves it set. If the flag is set and cleared in the same cycle, the set wins.
- R6: A command written while busy is set is ignored: the command readback keeps the running index. Such a write sets the sticky overrun flag (status bit 1), which is cleared by writing 1 to that bit.
- R7: Timing register bits 7:0 give the SCL high phase length minus one. Bits 15:8 give the low phase length minus one, with a floor of one. Larger values lengthen a transfer.
- R8: With the reset timing, busy clears within 180 cycles of acceptance for a write and within 280 cycles for a read.
- R9: While SCL stays high, the data line changes only as part of a start or stop condition.
- R10: A command written in the first cycle that busy reads 0 is accepted without an overrun.
- R11: A read that aborts leaves status bits 31:24 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_wsel | input | 2 | Write target: 0 command, 1 status, 2 timing |
| host_wdata | input | 32 | Host write data |
| host_rsel | input | 2 | Read target, same encoding |
| host_rdata | output | 32 | Read data for host_rsel |
| scl_o | output | 1 | Serial clock, push-pull |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| sda_i | input | 1 | Sensed level of the data line |

## Verification
The abort flag can be raised by the engine in the same cycle that the host writes a one to clear it. The bench first measures, with a silent slave, how many cycles after acceptance the flag appears. It then repeats that transfer and places the clearing write on exactly that edge. The result is judged correct when the flag still reads 1 one cycle later and reads 0 after a later, isolated clear. A second pairing is also exercised: a new command arriving in the same cycle that busy falls is accepted, and a command arriving while busy is refused with overrun.

// File: rtl/rbi_pkg.sv
package rbi_pkg;
    localparam int REG_W     = 32;
    localparam int IDX_LSB   = 17;
    localparam int BUSY_BIT  = 16;
    localparam int WR_BIT    = 8;
    localparam int RBYTE_LSB = 24;
    localparam int ABORT_BIT = 0;
    localparam int OVR_BIT   = 1;
    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_TIME = 2'd2;
    localparam logic [REG_W-1:0] TIMING_RST = 32'h0101_0101;

    typedef enum logic [1:0] {SYM_BIT, SYM_START, SYM_STOP} sym_e;
endpackage

// File: rtl/rbi_bit_phy.sv
module rbi_bit_phy
    import rbi_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] hi_len,
    input  logic [PH_W-1:0] lo_len,
    input  logic            go,
    input  sym_e            go_sym,
    input  logic            go_tx,
    output logic            done,
    output logic            rx_bit,
    output logic            scl_o,
    output logic            sda_oe,
    input  logic            sda_i
);
    typedef enum logic [1:0] {PH_A, PH_B, PH_C} phase_e;
    typedef struct packed {
        logic            active;
        sym_e            sym;
        logic            tx;
        phase_e          phase;
        logic [PH_W-1:0] cnt;
        logic            hold;
        logic            line;
    } phy_st_t;

    phy_st_t q, d;
    logic [PH_W-1:0] lo_eff;
    logic            level;

    // Data level of each phase for each symbol.
    function automatic logic phase_level(sym_e s, phase_e p, logic t);
        case (s)
            SYM_START: return (p != PH_C);
            SYM_STOP:  return (p == PH_C);
            default:   return t;
        endcase
    endfunction

    always_comb begin
        d      = q;
        done   = 1'b0;
        lo_eff = (lo_len == '0) ? PH_W'(1) : lo_len;
        if (!q.active)
            level = q.line;
        else if (q.phase == PH_A && q.hold)
            level = q.line;            // hold data for one cycle after SCL falls
        else
            level = phase_level(q.sym, q.phase, q.tx);
        d.line = level;
        if (!q.active) begin
            if (go) begin
                d.active = 1'b1;
                d.sym    = go_sym;
                d.tx     = go_tx;
                d.phase  = PH_A;
                d.cnt    = lo_eff;
                d.hold   = 1'b1;
            end
        end else begin
            d.hold = 1'b0;
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
            end else begin
                case (q.phase)
                    PH_A: begin
                        d.phase = PH_B;
                        d.cnt   = hi_len;
                    end
                    PH_B: begin
                        if (q.sym == SYM_BIT) begin
                            done     = 1'b1;
                            d.active = 1'b0;
                        end else begin
                            d.phase = PH_C;
                            d.cnt   = hi_len;
                        end
                    end
                    default: begin
                        done     = 1'b1;
                        d.active = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{active: 1'b0, sym: SYM_BIT, tx: 1'b1, phase: PH_A,
                   cnt: '0, hold: 1'b0, line: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_o  = !(q.active && q.phase == PH_A);
    assign sda_oe = !level;
    assign rx_bit = sda_i;

    assert_sda_stable_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && !(q.active && q.phase == PH_C)) |-> (level == $past(level)));
endmodule

// File: rtl/rbi_txn_seq.sv
module rbi_txn_seq
    import rbi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] start_idx,
    input  logic [7:0] start_data,
    input  logic       start_wr,
    output logic       go,
    output sym_e       go_sym,
    output logic       go_tx,
    input  logic       phy_done,
    input  logic       rx_bit,
    output logic       done_o,
    output logic       abort_o,
    output logic       rdv_o,
    output logic [7:0] rbyte_o
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR_W, ST_INDEX, ST_DATA,
        ST_RSTART, ST_ADDR_R, ST_RDBYTE, ST_STOP
    } stage_e;
    typedef struct packed {
        stage_e     stage;
        logic [3:0] bitcnt;
        logic       issued;
        logic [7:0] idx;
        logic [7:0] wdata;
        logic       is_wr;
        logic [7:0] shreg;
    } seq_st_t;

    localparam logic [3:0] ACK_SLOT = 4'd8;

    seq_st_t    q, d;
    logic [7:0] cur_byte;

    always_comb begin
        d       = q;
        go      = 1'b0;
        go_sym  = SYM_BIT;
        go_tx   = 1'b1;
        done_o  = 1'b0;
        abort_o = 1'b0;
        rdv_o   = 1'b0;
        case (q.stage)
            ST_ADDR_W: cur_byte = {DEV_ADDR, 1'b0};
            ST_INDEX:  cur_byte = q.idx;
            ST_DATA:   cur_byte = q.wdata;
            ST_ADDR_R: cur_byte = {DEV_ADDR, 1'b1};
            default:   cur_byte = 8'hFF;   // read byte: release, then NACK
        endcase
        case (q.stage)
            ST_START, ST_RSTART: go_sym = SYM_START;
            ST_STOP:             go_sym = SYM_STOP;
            default: go_tx = (q.bitcnt != ACK_SLOT) ? cur_byte[3'd7 - q.bitcnt[2:0]] : 1'b1;
        endcase
        if (q.stage == ST_IDLE) begin
            if (start) begin
                d.stage  = ST_START;
                d.idx    = start_idx;
                d.wdata  = start_data;
                d.is_wr  = start_wr;
                d.bitcnt = '0;
                d.issued = 1'b0;
            end
        end else begin
            if (!q.issued) begin
                go       = 1'b1;
                d.issued = 1'b1;
            end
            if (phy_done) begin
                d.issued = 1'b0;
                case (q.stage)
                    ST_START:  d.stage = ST_ADDR_W;
                    ST_RSTART: d.stage = ST_ADDR_R;
                    ST_STOP: begin
                        d.stage = ST_IDLE;
                        done_o  = 1'b1;
                    end
                    default: begin
                        if (q.bitcnt != ACK_SLOT) begin
                            if (q.stage == ST_RDBYTE) d.shreg = {q.shreg[6:0], rx_bit};
                            d.bitcnt = q.bitcnt + 1'b1;
                        end else begin
                            d.bitcnt = '0;
                            if (q.stage != ST_RDBYTE && rx_bit) begin
                                abort_o = 1'b1;
                                d.stage = ST_STOP;
                            end else begin
                                case (q.stage)
                                    ST_ADDR_W: d.stage = ST_INDEX;
                                    ST_INDEX:  d.stage = q.is_wr ? ST_DATA : ST_RSTART;
                                    ST_ADDR_R: d.stage = ST_RDBYTE;
                                    ST_RDBYTE: begin
                                        rdv_o   = 1'b1;
                                        d.stage = ST_STOP;
                                    end
                                    default:   d.stage = ST_STOP;
                                endcase
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{stage: ST_IDLE, bitcnt: '0, issued: 1'b0, idx: '0,
                   wdata: '0, is_wr: 1'b0, shreg: '0};
        end else begin
            q <= d;
        end
    end

    assign rbyte_o = q.shreg;

    assert_abort_goes_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (q.stage == ST_STOP));
endmodule

// File: rtl/rbi_bridge_top.sv
module rbi_bridge_top
    import rbi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         PH_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_wsel,
    input  logic [31:0] host_wdata,
    input  logic [1:0]  host_rsel,
    output logic [31:0] host_rdata,
    output logic        scl_o,
    output logic        sda_oe,
    input  logic        sda_i
);
    typedef struct packed {
        logic             busy;
        logic [7:0]       idx;
        logic [7:0]       wdata;
        logic             is_wr;
        logic [7:0]       rbyte;
        logic             abort;
        logic             ovr;
        logic [REG_W-1:0] timing;
    } host_st_t;

    host_st_t   q, d;
    logic       cmd_wr, accept, stat_wr;
    logic       go, go_tx, phy_done, rx_bit;
    sym_e       go_sym;
    logic       seq_done, seq_abort, seq_rdv;
    logic [7:0] seq_rbyte;

    always_comb begin
        d       = q;
        cmd_wr  = host_we && host_wsel == SEL_CMD;
        stat_wr = host_we && host_wsel == SEL_STAT;
        accept  = cmd_wr && !q.busy;
        if (accept) begin
            d.busy  = 1'b1;
            d.idx   = host_wdata[IDX_LSB +: 8];
            d.wdata = host_wdata[7:0];
            d.is_wr = host_wdata[WR_BIT];
        end
        if (seq_done) d.busy = 1'b0;
        if (seq_rdv)  d.rbyte = seq_rbyte;
        d.abort = seq_abort || (q.abort && !(stat_wr && host_wdata[ABORT_BIT]));
        d.ovr   = (cmd_wr && q.busy) || (q.ovr && !(stat_wr && host_wdata[OVR_BIT]));
        if (host_we && host_wsel == SEL_TIME) d.timing = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, idx: '0, wdata: '0, is_wr: 1'b0, rbyte: '0,
                   abort: 1'b0, ovr: 1'b0, timing: TIMING_RST};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (host_rsel)
            SEL_CMD:  host_rdata = {7'd0, q.idx, q.busy, 7'd0, q.is_wr, q.wdata};
            SEL_STAT: host_rdata = {q.rbyte, 22'd0, q.ovr, q.abort};
            SEL_TIME: host_rdata = q.timing;
            default:  host_rdata = '0;
        endcase
    end

    rbi_txn_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .start_idx(host_wdata[IDX_LSB +: 8]), .start_data(host_wdata[7:0]),
        .start_wr(host_wdata[WR_BIT]), .go(go), .go_sym(go_sym), .go_tx(go_tx),
        .phy_done(phy_done), .rx_bit(rx_bit), .done_o(seq_done),
        .abort_o(seq_abort), .rdv_o(seq_rdv), .rbyte_o(seq_rbyte)
    );

    rbi_bit_phy #(.PH_W(PH_W)) u_phy (
        .clk(clk), .rst_n(rst_n),
        .hi_len(q.timing[PH_W-1:0]), .lo_len(q.timing[8 +: PH_W]),
        .go(go), .go_sym(go_sym), .go_tx(go_tx), .done(phy_done),
        .rx_bit(rx_bit), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wsel == SEL_CMD && !q.busy) |=> q.busy);
    assert_bus_free_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> (scl_o && !sda_oe));
    assert_ignored_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wsel == SEL_CMD && q.busy) |=> ($stable(q.idx) && q.ovr));
    assert_abort_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |=> q.abort);
    assert_abort_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.abort && !(host_we && host_wsel == SEL_STAT && host_wdata[ABORT_BIT])) |=> q.abort);
endmodule

// File: tb/sim_rbi_bridge_top.sv
module sim_rbi_bridge_top;
    localparam logic [6:0] SLV_ADDR = 7'h2C;
    localparam logic [1:0] S_CMD = 2'd0, S_STAT = 2'd1, S_TIME = 2'd2;
    // {write, index, data, expected}
    localparam int NV = 8;
    localparam logic [24:0] VECS [NV] = '{
        {1'b1, 8'h10, 8'hA5, 8'h00}, {1'b1, 8'h11, 8'h3C, 8'h00},
        {1'b1, 8'hFF, 8'h81, 8'h00}, {1'b0, 8'h10, 8'h00, 8'hA5},
        {1'b0, 8'hFF, 8'h00, 8'h81}, {1'b1, 8'h00, 8'h00, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'h00}, {1'b0, 8'h11, 8'h00, 8'h3C}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [1:0] host_wsel = 2'd0, host_rsel = 2'd0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic scl, m_oe, s_oe = 1'b0, sda_line;
    int checks = 0, errors = 0;
    bit mute = 1'b0;

    assign sda_line = ~(m_oe | s_oe);
    always #5 clk = ~clk;

    rbi_bridge_top #(.DEV_ADDR(SLV_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wsel(host_wsel),
        .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
        .scl_o(scl), .sda_oe(m_oe), .sda_i(sda_line)
    );

    // Behavioural slave with a 256-byte register file.
    typedef enum int {M_IDLE, M_ADDR, M_INDEX, M_WDATA, M_RD} smode_t;
    smode_t smode = M_IDLE;
    int sbit = 0;
    logic [7:0] sshift = '0, sptr = '0;
    logic [7:0] smem [256];

    always @(negedge sda_line) if (scl === 1'b1) begin smode = M_ADDR; sbit = 0; s_oe = 1'b0; end
    always @(posedge sda_line) if (scl === 1'b1) begin smode = M_IDLE; sbit = 0; s_oe = 1'b0; end
    always @(posedge scl) if (smode != M_IDLE) begin
        if (sbit < 8) begin
            if (smode != M_RD) sshift = {sshift[6:0], sda_line};
        end else if (smode == M_RD && sda_line) smode = M_IDLE;
        sbit++;
    end
    always @(negedge scl) begin
        if (sbit == 8) begin
            case (smode)
                M_ADDR: if (!mute && sshift[7:1] == SLV_ADDR) begin
                            s_oe = 1'b1; smode = sshift[0] ? M_RD : M_INDEX;
                        end else smode = M_IDLE;
                M_INDEX: begin sptr = sshift; s_oe = 1'b1; smode = M_WDATA; end
                M_WDATA: begin smem[sptr] = sshift; sptr++; s_oe = 1'b1; end
                M_RD:    s_oe = 1'b0;
                default: s_oe = 1'b0;
            endcase
        end else if (sbit == 9) begin
            sbit = 0; s_oe = 1'b0;
            if (smode == M_RD) s_oe = ~smem[sptr][7];
        end else if (smode == M_RD && sbit > 0) s_oe = ~smem[sptr][7-sbit];
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] cmdw(logic w, logic [7:0] idx, logic [7:0] dat);
        return (32'(idx) << 17) | (32'(w) << 8) | 32'(dat);
    endfunction

    // Called at a negedge; drives one host write and returns at the next negedge.
    task automatic hw(logic [1:0] sel, logic [31:0] dat);
        host_we = 1'b1; host_wsel = sel; host_wdata = dat;
        @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic hr(logic [1:0] sel, output logic [31:0] v);
        host_rsel = sel; #1; v = host_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 1;
        hr(S_CMD, v);
        while (v[16] && cyc < 5000) begin
            @(negedge clk); cyc++; hr(S_CMD, v);
        end
    endtask

    task automatic run_cmd(logic w, logic [7:0] idx, logic [7:0] dat, output int cyc);
        logic [31:0] v;
        hw(S_CMD, cmdw(w, idx, dat));
        hr(S_CMD, v);
        chk("R2 busy after accept", 32'(v[16]), 32'd1);
        wait_idle(cyc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc, fast, k;
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hr(S_CMD, v);  chk("R1 cmd readback", v, 32'h0);
        hr(S_STAT, v); chk("R1 status", v, 32'h0);
        hr(S_TIME, v); chk("R1 timing", v, 32'h0101_0101);
        chk("R1 scl idle", 32'(scl), 32'd1);
        chk("R1 sda idle", 32'(sda_line), 32'd1);

        // Vector table: R3 writes, R4 reads, R8 duration
        for (int i = 0; i < NV; i++) begin
            logic w; logic [7:0] idx, dat, ex;
            {w, idx, dat, ex} = VECS[i];
            run_cmd(w, idx, dat, cyc);
            chk(w ? "R8 write time" : "R8 read time", 32'(cyc <= (w ? 180 : 280)), 32'd1);
            chk("R2 bus released", 32'({scl, sda_line}), 32'd3);
            if (w) chk("R3 slave holds data", 32'(smem[idx]), 32'(dat));
            else begin
                hr(S_STAT, v);
                chk("R4 read byte", 32'(v[31:24]), 32'(ex));
            end
            if (i == 0) fast = cyc;
        end

        // R10 back-to-back: issue in first idle cycle
        run_cmd(1'b1, 8'h20, 8'h5A, cyc);
        hw(S_CMD, cmdw(1'b1, 8'h21, 8'hC3));
        hr(S_CMD, v); chk("R10 accepted at once", 32'(v[16]), 32'd1);
        hr(S_STAT, v); chk("R10 no overrun", 32'(v[1]), 32'd0);
        wait_idle(cyc);
        chk("R10 second write landed", 32'(smem[8'h21]), 32'h0000_00C3);

        // R6 command while busy
        hw(S_CMD, cmdw(1'b1, 8'h40, 8'h77));
        hw(S_CMD, cmdw(1'b1, 8'h41, 8'h99));
        hr(S_STAT, v); chk("R6 overrun set", 32'(v[1]), 32'd1);
        hr(S_CMD, v);  chk("R6 index kept", 32'(v[24:17]), 32'h40);
        wait_idle(cyc);
        chk("R6 first write done", 32'(smem[8'h40]), 32'h77);
        chk("R6 second write ignored", 32'(smem[8'h41]), 32'h00);
        hw(S_STAT, 32'h2);
        hr(S_STAT, v); chk("R6 overrun cleared", 32'(v[1]), 32'd0);

        // R7 slower timing lengthens transfer
        hw(S_TIME, 32'h0000_0303);
        run_cmd(1'b1, 8'h50, 8'h3E, cyc);
        chk("R7 slower timing", 32'(cyc * 2 > fast * 3), 32'd1);
        chk("R7 data still correct", 32'(smem[8'h50]), 32'h3E);
        hw(S_TIME, 32'h0101_0101);

        // R5 missing acknowledge, R11 read byte kept
        run_cmd(1'b0, 8'h10, 8'h00, cyc);     // status byte becomes A5
        mute = 1'b1;
        run_cmd(1'b0, 8'h11, 8'h00, cyc);
        hr(S_STAT, v);
        chk("R5 abort set", 32'(v[0]), 32'd1);
        chk("R11 read byte kept", 32'(v[31:24]), 32'hA5);
        chk("R5 stop sent", 32'({scl, sda_line}), 32'd3);
        hw(S_STAT, 32'h0);
        hr(S_STAT, v); chk("R5 write 0 keeps flag", 32'(v[0]), 32'd1);
        hw(S_STAT, 32'h1);
        hr(S_STAT, v); chk("R5 write 1 clears flag", 32'(v[0]), 32'd0);

        // R5 set and clear in the same cycle: measure, then collide
        hw(S_CMD, cmdw(1'b1, 8'h60, 8'h11));
        k = 0;
        hr(S_STAT, v);
        while (!v[0] && k < 2000) begin @(negedge clk); k++; hr(S_STAT, v); end
        wait_idle(cyc);
        hw(S_STAT, 32'h1);
        hw(S_CMD, cmdw(1'b1, 8'h60, 8'h11));
        repeat (k - 1) @(negedge clk);
        hr(S_STAT, v); chk("R5 flag clear before set edge", 32'(v[0]), 32'd0);
        hw(S_STAT, 32'h1);
        hr(S_STAT, v); chk("R5 set wins over clear", 32'(v[0]), 32'd1);
        wait_idle(cyc);
        hw(S_STAT, 32'h1);
        hr(S_STAT, v); chk("R5 later clear", 32'(v[0]), 32'd0);
        mute = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule